// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models the device side of the status-polling scheme of a parallel NOR flash. While an internal program or erase runs, or while an erase is suspended, reads of the flash do not return array contents. They return a status byte instead. That byte carries a data-polling bit, two toggle bits with different toggle rules, a time-limit flag and an erase marker. The block also drives the ready/busy level.

The block does not contain the program and erase sequencers, the command decoder or the array. The current operating mode, the sector-match flag for the read address, the bit 7 of the data being programmed, the time-limit flag and the array read data all arrive as inputs.

Each rising edge of the read strobe is one read. On that edge the block latches either the status byte or the array data into a registered output. The two toggle flip-flops advance on the same edge when the mode and the address qualify. The host polling routine can then follow the usual pattern: read twice and compare the toggle bits. When the mode returns to normal reading, the next read returns array data and ready is high.

Top module: `flash_status_gen`

## Requirements
- R1: In the cycle after synchronous reset, `rdata_o` is 0 and `ready_o` is 1. Both toggle states start at 0.
- R2: `ready_o` is 0 one clock after `mode_i` is 1 (program), 2 (erase) or 4 (program during erase suspend). It is 1 one clock after `mode_i` is 0 (read array), 3 (erase suspended) or any other code.
- R3: `rdata_o` changes only in the clock after a rising edge of `rd_i` is sampled. Between read edges it holds its value, whatever the other inputs do.
- R4: In program mode (1), a read returns the following: bit 7 is the complement of `prog_bit7_i`, bit 6 is the toggle-A state, bit 3 is 0 and bit 2 is the toggle-B state. Toggle A inverts after every such read. Toggle B does not invert.
- R5: In erase mode (2), a read returns bit 7 = 0, bit 6 = toggle A and bit 3 = 1. Toggle A inverts after every read. Bit 2 shows toggle B, which inverts only when `sector_sel_i` is 1.
- R6: In suspend mode (3) with `sector_sel_i` = 1, a read returns bit 7 = 1, bit 6 = the held toggle-A state (no inversion), bits 5 and 3 = 0, and bit 2 = toggle B, which inverts after the read.
- R7: A read in mode 0, in any undefined mode code (5 to 7), or in mode 3 with `sector_sel_i` = 0 returns `array_data_i` unchanged. No toggle state moves.
- R8: In mode 4, a read returns the same status as in program mode. Toggle A inverts and toggle B holds.
- R9: In modes 1, 2 and 4, bit 5 of the returned byte equals `timeout_i` as sampled at the read edge.
- R10: In every status-returning read, bits 4, 1 and 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode code (0 read, 1 program, 2 erase, 3 suspended, 4 suspend-program) |
| rd_i | input | 1 | Read strobe; a rising edge starts one read |
| sector_sel_i | input | 1 | Read address lies in a sector selected for erase or suspended |
| prog_bit7_i | input | 1 | Bit 7 of the data being programmed |
| timeout_i | input | 1 | Embedded operation exceeded its time limit |
| array_data_i | input | DATA_W | Array read data |
| rdata_o | output | DATA_W | Registered read data |
| ready_o | output | 1 | Ready (1) / busy (0) level |

## Verification
The bound checker tests on every cycle the parts of the output that can be stated bit by bit. These are the ready level against the mode, the hold of the read data between strobe edges, the polling bit against the programmed bit, the erase marker, the suspended-sector pattern, the time-limit bit, the zero spare bits and array pass-through. A single-cycle property cannot show that a toggle bit alternates across separate reads, or that a toggle bit stays put when the address does not match. The bench shows these with its reference toggle model over random read sequences and with directed back-to-back polls. The bench also covers leaving an operation and reading array data again.

// File: rtl/fsg_pkg.sv
`timescale 1ns/1ps
package fsg_pkg;
  // mode codes (values are part of the interface)
  localparam logic [2:0] MODE_READ      = 3'd0;
  localparam logic [2:0] MODE_PROG      = 3'd1;
  localparam logic [2:0] MODE_ERASE     = 3'd2;
  localparam logic [2:0] MODE_SUSP      = 3'd3;
  localparam logic [2:0] MODE_SUSP_PROG = 3'd4;

  // status bit positions decoded by host polling software
  localparam int POS_POLL   = 7;
  localparam int POS_TGL_A  = 6;
  localparam int POS_LIMIT  = 5;
  localparam int POS_ERMARK = 3;
  localparam int POS_TGL_B  = 2;
endpackage

// File: rtl/fsg_read_edge.sv
`timescale 1ns/1ps
module fsg_read_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/fsg_toggle_bit.sv
`timescale 1ns/1ps
module fsg_toggle_bit (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output logic state_o
);
  always_ff @(posedge clk) begin
    if (rst)         state_o <= 1'b0;
    else if (step_i) state_o <= ~state_o;
  end
endmodule

// File: rtl/fsg_status_mux.sv
`timescale 1ns/1ps
module fsg_status_mux #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        mode_i,
  input  logic              sel_i,
  input  logic              prog_bit_i,
  input  logic              limit_i,
  input  logic [DATA_W-1:0] array_i,
  input  logic              tgl_a_i,
  input  logic              tgl_b_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              busy_o,
  output logic              step_a_o,
  output logic              step_b_o
);
  import fsg_pkg::*;

  always_comb begin
    byte_o   = '0;
    busy_o   = 1'b0;
    step_a_o = 1'b0;
    step_b_o = 1'b0;
    case (mode_i)
      MODE_PROG, MODE_SUSP_PROG: begin
        busy_o             = 1'b1;
        step_a_o           = 1'b1;
        byte_o[POS_POLL]   = ~prog_bit_i;
        byte_o[POS_TGL_A]  = tgl_a_i;
        byte_o[POS_LIMIT]  = limit_i;
        byte_o[POS_TGL_B]  = tgl_b_i;
      end
      MODE_ERASE: begin
        busy_o             = 1'b1;
        step_a_o           = 1'b1;
        step_b_o           = sel_i;
        byte_o[POS_TGL_A]  = tgl_a_i;
        byte_o[POS_LIMIT]  = limit_i;
        byte_o[POS_ERMARK] = 1'b1;
        byte_o[POS_TGL_B]  = tgl_b_i;
      end
      MODE_SUSP: begin
        if (sel_i) begin
          step_b_o          = 1'b1;
          byte_o[POS_POLL]  = 1'b1;
          byte_o[POS_TGL_A] = tgl_a_i;
          byte_o[POS_TGL_B] = tgl_b_i;
        end else begin
          byte_o = array_i;
        end
      end
      default: byte_o = array_i;
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
module flash_status_gen #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_i,
  input  logic              rd_i,
  input  logic              sector_sel_i,
  input  logic              prog_bit7_i,
  input  logic              timeout_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o
);
  localparam int N_TGL = 2;

  logic              rd_rise;
  logic [DATA_W-1:0] next_byte;
  logic              busy;
  logic [N_TGL-1:0]  tgl_state;
  logic [N_TGL-1:0]  tgl_en;

  fsg_read_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (rd_i),
    .rise_o   (rd_rise)
  );

  for (genvar g = 0; g < N_TGL; g++) begin : g_tgl
    fsg_toggle_bit u_tgl (
      .clk     (clk),
      .rst     (rst),
      .step_i  (rd_rise & tgl_en[g]),
      .state_o (tgl_state[g])
    );
  end

  fsg_status_mux #(.DATA_W(DATA_W)) u_mux (
    .mode_i     (mode_i),
    .sel_i      (sector_sel_i),
    .prog_bit_i (prog_bit7_i),
    .limit_i    (timeout_i),
    .array_i    (array_data_i),
    .tgl_a_i    (tgl_state[0]),
    .tgl_b_i    (tgl_state[1]),
    .byte_o     (next_byte),
    .busy_o     (busy),
    .step_a_o   (tgl_en[0]),
    .step_b_o   (tgl_en[1])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      ready_o <= 1'b1;
    end else begin
      ready_o <= ~busy;
      if (rd_rise) rdata_o <= next_byte;
    end
  end
endmodule

// File: rtl/fsg_checker.sv
`timescale 1ns/1ps
module fsg_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        mode_i,
  input logic              rd_i,
  input logic              sector_sel_i,
  input logic              prog_bit7_i,
  input logic              timeout_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ready_o
);
  logic rd_seen;
  logic edge_now;
  logic busy_mode;

  always_ff @(posedge clk) begin
    if (rst) rd_seen <= 1'b0;
    else     rd_seen <= rd_i;
  end

  assign edge_now  = rd_i && !rd_seen;
  assign busy_mode = (mode_i == 3'd1) || (mode_i == 3'd2) || (mode_i == 3'd4);

  AST_BUSY_LEVEL: assert property (@(posedge clk) disable iff (rst)
    busy_mode |=> !ready_o); // R2
  AST_READY_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !busy_mode |=> ready_o); // R2
  AST_HOLD_BETWEEN_READS: assert property (@(posedge clk) disable iff (rst)
    !edge_now |=> $stable(rdata_o)); // R3
  AST_POLL_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    (edge_now && (mode_i == 3'd1 || mode_i == 3'd4)) |=> (rdata_o[7] != $past(prog_bit7_i))); // R4
  AST_ERASE_MARKS: assert property (@(posedge clk) disable iff (rst)
    (edge_now && mode_i == 3'd2) |=> (!rdata_o[7] && rdata_o[3])); // R5
  AST_SUSP_SECTOR: assert property (@(posedge clk) disable iff (rst)
    (edge_now && mode_i == 3'd3 && sector_sel_i) |=> (rdata_o[7] && !rdata_o[5] && !rdata_o[3])); // R6
  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (rst)
    (edge_now && (mode_i == 3'd0 || mode_i > 3'd4 || (mode_i == 3'd3 && !sector_sel_i)))
      |=> (rdata_o == $past(array_data_i))); // R7
  AST_LIMIT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (edge_now && busy_mode) |=> (rdata_o[5] == $past(timeout_i))); // R9
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (edge_now && busy_mode) |=> (!rdata_o[4] && !rdata_o[1] && !rdata_o[0])); // R10
endmodule

bind flash_status_gen fsg_checker #(.DATA_W(DATA_W)) u_fsg_checker (
  .clk          (clk),
  .rst          (rst),
  .mode_i       (mode_i),
  .rd_i         (rd_i),
  .sector_sel_i (sector_sel_i),
  .prog_bit7_i  (prog_bit7_i),
  .timeout_i    (timeout_i),
  .array_data_i (array_data_i),
  .rdata_o      (rdata_o),
  .ready_o      (ready_o)
);

// File: tb/test_flash_status_gen.sv
`timescale 1ns/1ps
module test_flash_status_gen;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mode_i = 3'd0;
  logic          rd_i = 1'b0;
  logic          sector_sel_i = 1'b0;
  logic          prog_bit7_i = 1'b0;
  logic          timeout_i = 1'b0;
  logic [DW-1:0] array_data_i = '0;
  logic [DW-1:0] rdata_o;
  logic          ready_o;

  int checks = 0;
  int fails  = 0;
  bit m_a = 1'b0;
  bit m_b = 1'b0;
  logic [DW-1:0] last_rd;

  always #2 clk = ~clk;

  flash_status_gen #(.DATA_W(DW)) i_flash_status_gen (
    .clk(clk), .rst(rst), .mode_i(mode_i), .rd_i(rd_i),
    .sector_sel_i(sector_sel_i), .prog_bit7_i(prog_bit7_i),
    .timeout_i(timeout_i), .array_data_i(array_data_i),
    .rdata_o(rdata_o), .ready_o(ready_o)
  );

  function automatic bit is_busy(logic [2:0] m);
    return (m == 3'd1) || (m == 3'd2) || (m == 3'd4);
  endfunction

  function automatic logic [DW-1:0] expect_byte(logic [2:0] m, bit sel, bit b7,
                                                bit lim, logic [DW-1:0] d, bit ta, bit tb);
    logic [DW-1:0] r = '0;
    if (m == 3'd1 || m == 3'd4) begin
      r[7] = ~b7; r[6] = ta; r[5] = lim; r[2] = tb;
    end else if (m == 3'd2) begin
      r[6] = ta; r[5] = lim; r[3] = 1'b1; r[2] = tb;
    end else if (m == 3'd3 && sel) begin
      r[7] = 1'b1; r[6] = ta; r[2] = tb;
    end else begin
      r = d;
    end
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] m, bit sel);
    case (m)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return sel ? "R6" : "R7";
      3'd4: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [2:0] m, bit sel, bit b7, bit lim, logic [DW-1:0] d);
    logic [DW-1:0] exp;
    @(negedge clk);
    mode_i = m; sector_sel_i = sel; prog_bit7_i = b7; timeout_i = lim; array_data_i = d;
    rd_i = 1'b1;
    exp = expect_byte(m, sel, b7, lim, d, m_a, m_b);
    if (is_busy(m)) m_a = ~m_a;
    if (sel && (m == 3'd2 || m == 3'd3)) m_b = ~m_b;
    @(negedge clk);
    rd_i = 1'b0;
    last_rd = rdata_o;
    check(rdata_o == exp, tag_of(m, sel), rdata_o, exp);
    check(ready_o == !is_busy(m), "R2", {7'd0, ready_o}, {7'd0, !is_busy(m)});
    if (is_busy(m)) begin
      check(rdata_o[5] == lim, "R9", {7'd0, rdata_o[5]}, {7'd0, lim});
      check(rdata_o[4] == 1'b0 && rdata_o[1:0] == 2'b00, "R10", rdata_o, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] p0, p1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rdata_o == '0, "R1", rdata_o, '0);
    check(ready_o == 1'b1, "R1", {7'd0, ready_o}, 8'd1);

    // directed: back-to-back erase polls in a selected sector alternate both toggles (R5)
    do_read(3'd2, 1'b1, 1'b0, 1'b0, 8'h5A); p0 = last_rd;
    do_read(3'd2, 1'b1, 1'b0, 1'b0, 8'h5A); p1 = last_rd;
    check(p0[6] != p1[6] && p0[2] != p1[2], "R5", p1, p0 ^ 8'h44);
    // erase poll outside selected sector: toggle B holds (R5)
    do_read(3'd2, 1'b0, 1'b0, 1'b0, 8'h00); p0 = last_rd;
    do_read(3'd2, 1'b0, 1'b0, 1'b0, 8'h00); p1 = last_rd;
    check(p0[2] == p1[2], "R5", p1, p0 ^ 8'h40);
    // program polls: toggle B holds, toggle A alternates (R4)
    do_read(3'd1, 1'b1, 1'b1, 1'b0, 8'hFF); p0 = last_rd;
    do_read(3'd1, 1'b1, 1'b1, 1'b1, 8'hFF); p1 = last_rd;
    check(p0[6] != p1[6] && p0[2] == p1[2], "R4", p1, p0 ^ 8'h60);
    // suspended sector: toggle A frozen (R6)
    do_read(3'd3, 1'b1, 1'b0, 1'b1, 8'h33); p0 = last_rd;
    do_read(3'd3, 1'b1, 1'b0, 1'b1, 8'h33); p1 = last_rd;
    check(p0[6] == p1[6] && p0[2] != p1[2], "R6", p1, p0 ^ 8'h04);
    // no read edge: output holds while inputs move (R3)
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      mode_i = 3'(k); array_data_i = 8'($urandom); timeout_i = k[0];
    end
    @(negedge clk);
    check(rdata_o == p1, "R3", rdata_o, p1);
    // operation ends: next read gives array data, ready high (R7)
    do_read(3'd0, 1'b1, 1'b0, 1'b0, 8'hC3);
    do_read(3'd6, 1'b0, 1'b1, 1'b1, 8'h96);
    // suspend-program polls (R8)
    do_read(3'd4, 1'b0, 1'b0, 1'b1, 8'h11);
    do_read(3'd4, 1'b1, 1'b1, 1'b0, 8'h22);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] m = 3'($urandom_range(0, 6));
      do_read(m, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
      if (($urandom & 3) == 0) repeat (2) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule